// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block generates the scan timing for a TFT panel: a pixel-clock enable and a pixel clock derived from the core clock, plus horizontal sync, vertical sync and data-enable. Software programs it through a small write port that reaches three timing words and one control word. The timing words describe active width, active height, front porch, sync width and back porch on each axis. The control word holds the raster enable, the pixel clock divisor and three polarity-inversion bits.

Each line runs through active pixels, then front porch, then sync, then back porch. Each frame runs through the same four phases counted in lines. The horizontal porches and sync width are stored as count minus one. The vertical porches are stored as plain line counts, while the vertical sync width is stored minus one. Active width is given in steps of 16 pixels. The widest fields are split between a base word and an extension word, which allows up to 2048 pixels per line and 2048 lines per frame. Timing words take effect at frame boundaries, so a running display never shows a torn frame.

Top module: `lcd_raster_tg`

## Requirements
- R1: With the raster running, `pix_ce_o` is high for one core clock in every D clocks, where D is control bits 15:8. A divisor of 0 or 1 behaves as 2. The first pulse comes D clocks after enable, on the last count of the first period.
- R2: `pclk_o` is high during the first floor(D/2) clocks of each divisor period and low for the rest. Control bit 18 inverts it.
- R3: A line is A+F+S+B pixel clocks long: A active pixels, then F front porch, then S sync, then B back porch. F, S and B are the stored values plus one. `hsync_o` is active exactly during the S sync pixels.
- R4: A frame is L+VF+VS+VB lines long, in the order active, front porch, sync, back porch. L is the stored lines value plus one, VF and VB are the stored values with no bias, and VS is the stored value plus one. `vsync_o` is active for the whole of every sync line.
- R5: The write port selects a word with `reg_addr`: 0 is the horizontal word, 1 the vertical word, 2 the extension word, 3 control. In the horizontal word, back porch[7:0] is at bits 31:24, front porch[7:0] at 23:16, sync width[5:0] at 15:10, line-width code[5:0] at 9:4 and line-width code bit 6 at bit 3. A equals (code+1)*16.
- R6: The vertical word holds lines[9:0] at 9:0, sync width at 15:10, front porch at 23:16 and back porch at 31:24. The extension word holds horizontal front porch[9:8] at 1:0, horizontal back porch[9:8] at 5:4, lines bit 10 at bit 26 and horizontal sync width[9:6] at 30:27.
- R7: `de_o` is high only when both the pixel position and the line position are inside their active regions.
- R8: Control bit 16 inverts `hsync_o` and control bit 17 inverts `vsync_o`, both while scanning and while idle.
- R9: Control bit 0 is the raster enable. While it is low, `pix_ce_o` and `de_o` are 0, the syncs sit at their inactive level and `pclk_o` sits at its inversion level. Enabling starts at pixel 0 of line 0. After reset every output is 0.
- R10: A write to a timing word during a frame does not change that frame. It takes effect from the first pixel of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the configuration words |
| reg_addr | input | 2 | Word select: 0 horizontal, 1 vertical, 2 extension, 3 control |
| reg_wdata | input | 32 | Write data |
| pix_ce_o | output | 1 | Pixel clock enable, one core clock wide |
| pclk_o | output | 1 | Pixel clock with selectable polarity |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |

## Verification
The bench concentrates on the mixed field biases: vertical porches of zero, and single-pixel horizontal porches stored as zero. A design that applied the minus-one bias uniformly would shift every sync by one pixel or one line, and the pixel-by-pixel scoreboard would catch it. Extension bits are tested with a 1040-pixel line, 257-pixel porches, a 65-pixel sync and a 1025-line frame. A missing or misplaced extension bit would shorten the line or the frame by hundreds of clocks. The bench also rewrites the timing in the middle of a frame; a design without frame-boundary latching would change geometry mid-frame. Divisor values 0, 3 and 4 and an inverted pixel clock check the enable spacing and the clock duty cycle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int HW   = 13;  // horizontal counter / length width
  localparam int VW   = 12;  // vertical counter / length width
  localparam int DIVW = 8;   // pixel clock divisor width

  typedef enum logic [1:0] {
    ADDR_HTIM = 2'd0,
    ADDR_VTIM = 2'd1,
    ADDR_XTIM = 2'd2,
    ADDR_CTRL = 2'd3
  } tg_addr_e;

  localparam int CB_EN    = 0;
  localparam int CB_DIVLO = 8;
  localparam int CB_INVH  = 16;
  localparam int CB_INVV  = 17;
  localparam int CB_INVP  = 18;

  typedef struct packed {
    logic [HW-1:0] h_act;
    logic [HW-1:0] h_fp;
    logic [HW-1:0] h_sw;
    logic [HW-1:0] h_bp;
    logic [VW-1:0] v_act;
    logic [VW-1:0] v_fp;
    logic [VW-1:0] v_sw;
    logic [VW-1:0] v_bp;
  } tg_timing_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs import lcd_tg_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [1:0]      addr,
  input  logic [31:0]     wdata,
  input  logic            frame_end,
  output tg_timing_t      tim,
  output logic            raster_en,
  output logic            inv_h,
  output logic            inv_v,
  output logic            inv_p,
  output logic [DIVW-1:0] div
);
  logic [31:0] htim_q, vtim_q, xtim_q, ctrl_q;
  logic [31:0] htim_d, vtim_d, xtim_d, ctrl_d;
  logic [31:0] sh0_q, sh1_q, sh2_q;
  logic [31:0] sh0_d, sh1_d, sh2_d;
  logic        load;
  logic        unused_bits;

  assign load = !ctrl_q[CB_EN] || frame_end;

  always_comb begin
    htim_d = htim_q;
    vtim_d = vtim_q;
    xtim_d = xtim_q;
    ctrl_d = ctrl_q;
    if (wr) begin
      unique case (tg_addr_e'(addr))
        ADDR_HTIM: htim_d = wdata;
        ADDR_VTIM: vtim_d = wdata;
        ADDR_XTIM: xtim_d = wdata;
        ADDR_CTRL: ctrl_d = wdata;
        default:   ctrl_d = ctrl_q;
      endcase
    end
    sh0_d = load ? htim_q : sh0_q;
    sh1_d = load ? vtim_q : sh1_q;
    sh2_d = load ? xtim_q : sh2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htim_q <= '0;
      vtim_q <= '0;
      xtim_q <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      htim_q <= htim_d;
      vtim_q <= vtim_d;
      xtim_q <= xtim_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh0_q <= '0;
      sh1_q <= '0;
      sh2_q <= '0;
    end else if (load) begin
      sh0_q <= sh0_d;
      sh1_q <= sh1_d;
      sh2_q <= sh2_d;
    end
  end

  // Field decode with the per-field bias applied.
  always_comb begin
    tim.h_act = (HW'({sh0_q[3], sh0_q[9:4]}) + HW'(1)) << 4;
    tim.h_fp  = HW'({sh2_q[1:0], sh0_q[23:16]}) + HW'(1);
    tim.h_bp  = HW'({sh2_q[5:4], sh0_q[31:24]}) + HW'(1);
    tim.h_sw  = HW'({sh2_q[30:27], sh0_q[15:10]}) + HW'(1);
    tim.v_act = VW'({sh2_q[26], sh1_q[9:0]}) + VW'(1);
    tim.v_fp  = VW'(sh1_q[23:16]);
    tim.v_sw  = VW'(sh1_q[15:10]) + VW'(1);
    tim.v_bp  = VW'(sh1_q[31:24]);
  end

  assign raster_en = ctrl_q[CB_EN];
  assign inv_h     = ctrl_q[CB_INVH];
  assign inv_v     = ctrl_q[CB_INVV];
  assign inv_p     = ctrl_q[CB_INVP];
  assign div       = ctrl_q[CB_DIVLO +: DIVW];

  assign unused_bits = ^{sh0_q[2:0], sh2_q[3:2], sh2_q[25:6], sh2_q[31],
                         ctrl_q[7:1], ctrl_q[31:19]};
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          ce,
  output logic          pclk_raw
);
  logic [DW-1:0] cnt_q, cnt_d, div_eff;
  logic          wrap;

  always_comb begin
    div_eff  = (div < DW'(2)) ? DW'(2) : div;
    wrap     = (cnt_q >= div_eff - DW'(1));
    if (!en)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else          cnt_d = cnt_q + DW'(1);
    ce       = en && wrap;
    pclk_raw = en && (cnt_q < (div_eff >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] fp_len,
  input  logic [CW-1:0] sw_len,
  input  logic [CW-1:0] bp_len,
  output logic          active,
  output logic          sync,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] sync_beg, sync_end, total;
  logic          upd;

  always_comb begin
    sync_beg = act_len + fp_len;
    sync_end = sync_beg + sw_len;
    total    = sync_end + bp_len;
    last     = (cnt_q == total - CW'(1));
    upd      = !en || step;
    if (!en)       cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
    active   = (cnt_q < act_len);
    sync     = (cnt_q >= sync_beg) && (cnt_q < sync_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcd_raster_tg.sv
module lcd_raster_tg import lcd_tg_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        pix_ce_o,
  output logic        pclk_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o
);
  logic [1:0]      rs_q;
  logic            rst_sync_n;
  tg_timing_t      tim;
  logic            raster_en, inv_h, inv_v, inv_p;
  logic [DIVW-1:0] div;
  logic            pix_ce, pclk_raw;
  logic            h_act, h_sync, h_last;
  logic            v_act, v_sync, v_last;
  logic            frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  lcd_tg_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .frame_end(frame_end), .tim(tim),
    .raster_en(raster_en), .inv_h(inv_h), .inv_v(inv_v), .inv_p(inv_p),
    .div(div)
  );

  lcd_tg_clkdiv #(.DW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .en(raster_en), .div(div),
    .ce(pix_ce), .pclk_raw(pclk_raw)
  );

  lcd_tg_axis #(.CW(HW)) u_h (
    .clk(clk), .rst_n(rst_sync_n), .en(raster_en), .step(pix_ce),
    .act_len(tim.h_act), .fp_len(tim.h_fp), .sw_len(tim.h_sw),
    .bp_len(tim.h_bp), .active(h_act), .sync(h_sync), .last(h_last)
  );

  lcd_tg_axis #(.CW(VW)) u_v (
    .clk(clk), .rst_n(rst_sync_n), .en(raster_en), .step(pix_ce && h_last),
    .act_len(tim.v_act), .fp_len(tim.v_fp), .sw_len(tim.v_sw),
    .bp_len(tim.v_bp), .active(v_act), .sync(v_sync), .last(v_last)
  );

  assign frame_end = pix_ce && h_last && v_last;

  assign pix_ce_o = pix_ce;
  assign pclk_o   = pclk_raw ^ inv_p;
  assign hsync_o  = (raster_en && h_sync) ^ inv_h;
  assign vsync_o  = (raster_en && v_sync) ^ inv_v;
  assign de_o     = raster_en && h_act && v_act;
endmodule

// File: rtl/lcd_raster_tg_chk.sv
module lcd_raster_tg_chk import lcd_tg_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       inv_h,
  input logic       de,
  input logic       hsync,
  input logic       pix_ce,
  input logic       frame_end,
  input tg_timing_t tim
);
  // R1: divisor never below 2, so enables never come back to back
  a_r1_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  // R9: idle outputs while raster disabled
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!de && !pix_ce));

  // R3: sync never overlaps active pixels
  a_r3_de_no_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == inv_h));

  // R7: data enable only moves on a pixel step
  a_r7_de_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(pix_ce)) |-> $stable(de));

  // R10: latched timing holds for the whole frame
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(frame_end)) |-> $stable(tim));
endmodule

bind lcd_raster_tg lcd_raster_tg_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(raster_en), .inv_h(inv_h),
  .de(de_o), .hsync(hsync_o), .pix_ce(pix_ce_o), .frame_end(frame_end),
  .tim(tim)
);

// File: tb/lcd_raster_tg_tb.sv
module lcd_raster_tg_tb;
  typedef struct packed { logic hs; logic vs; logic de; } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        pix_ce_o, pclk_o, hsync_o, vsync_o, de_o;

  exp_t  exp_q[$];
  string cur_tag = "none";
  int    n_cmp = 0;
  int    n_bad = 0;

  always #4 clk = ~clk;

  lcd_raster_tg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_ce_o(pix_ce_o), .pclk_o(pclk_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per pixel step.
  always @(negedge clk) begin : mon
    exp_t e;
    exp_t g;
    if (rst_n && pix_ce_o && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      g = {hsync_o, vsync_o, de_o};
      n_cmp++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: got hs/vs/de=%b expected %b (left %0d)",
                 cur_tag, g, e, exp_q.size());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input logic en, input int dv,
                                      input logic ih, input logic iv, input logic ip);
    logic [31:0] r;
    r = '0;
    r[0] = en; r[15:8] = dv[7:0]; r[16] = ih; r[17] = iv; r[18] = ip;
    return r;
  endfunction

  // R5 / R6 field placement, computed from desired counts
  task automatic set_timing(input int w, input int hfp, input int hsw, input int hbp,
                            input int lines, input int vfp, input int vsw, input int vbp);
    logic [31:0] t0, t1, t2;
    int p, f, s, b, l, vs;
    p = w / 16 - 1; f = hfp - 1; s = hsw - 1; b = hbp - 1; l = lines - 1; vs = vsw - 1;
    t0 = '0; t1 = '0; t2 = '0;
    t0[31:24] = b[7:0]; t0[23:16] = f[7:0]; t0[15:10] = s[5:0];
    t0[9:4] = p[5:0]; t0[3] = p[6];
    t1[31:24] = vbp[7:0]; t1[23:16] = vfp[7:0]; t1[15:10] = vs[5:0]; t1[9:0] = l[9:0];
    t2[1:0] = f[9:8]; t2[5:4] = b[9:8]; t2[30:27] = s[9:6]; t2[26] = l[10];
    wr(2'd0, t0);
    wr(2'd1, t1);
    wr(2'd2, t2);
  endtask

  task automatic push_frame(input int w, input int hfp, input int hsw, input int hbp,
                            input int lines, input int vfp, input int vsw, input int vbp,
                            input logic ih, input logic iv);
    int ht, vt;
    ht = w + hfp + hsw + hbp;
    vt = lines + vfp + vsw + vbp;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        exp_t e;
        e.de = (h < w) && (v < lines);
        e.hs = ((h >= w + hfp) && (h < w + hfp + hsw)) ^ ih;
        e.vs = ((v >= lines + vfp) && (v < lines + vfp + vsw)) ^ iv;
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic pclk_test(input int dv, input logic ip, input string tag);
    int de_f;
    wr(2'd3, ctl(1'b1, dv, 1'b0, 1'b0, ip));
    de_f = (dv < 2) ? 2 : dv;
    for (int k = 0; k < 2 * de_f; k++) begin
      int c;
      c = k % de_f;
      chk({tag, " R1 pix_ce"}, {31'd0, pix_ce_o}, {31'd0, (c == de_f - 1)});
      chk({tag, " R2 pclk"}, {31'd0, pclk_o}, {31'd0, (c < de_f / 2) ^ ip});
      @(negedge clk);
    end
    wr(2'd3, 32'd0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    int ta, tb;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    chk("R9 reset pix_ce", {31'd0, pix_ce_o}, 32'd0);
    chk("R9 reset pclk",   {31'd0, pclk_o},   32'd0);
    chk("R9 reset hsync",  {31'd0, hsync_o},  32'd0);
    chk("R9 reset vsync",  {31'd0, vsync_o},  32'd0);
    chk("R9 reset de",     {31'd0, de_o},     32'd0);

    set_timing(32, 2, 3, 2, 4, 1, 2, 1);
    pclk_test(4, 1'b0, "div4");
    pclk_test(0, 1'b0, "div0");
    pclk_test(3, 1'b1, "div3 inv");

    // R8 / R9: idle levels follow inversion bits
    wr(2'd3, ctl(1'b0, 2, 1'b1, 1'b1, 1'b1));
    repeat (3) begin
      chk("R8 idle hsync", {31'd0, hsync_o}, 32'd1);
      chk("R8 idle vsync", {31'd0, vsync_o}, 32'd1);
      chk("R9 idle de",    {31'd0, de_o},    32'd0);
      chk("R9 idle ce",    {31'd0, pix_ce_o}, 32'd0);
      chk("R9 idle pclk",  {31'd0, pclk_o},  32'd1);
      @(negedge clk);
    end
    wr(2'd3, 32'd0);

    // R3 R4 R5 R7: two frames of geometry A
    cur_tag = "R3 R4 R5 R7 geometry A";
    push_frame(32, 2, 3, 2, 4, 1, 2, 1, 1'b0, 1'b0);
    push_frame(32, 2, 3, 2, 4, 1, 2, 1, 1'b0, 1'b0);
    wr(2'd3, ctl(1'b1, 2, 1'b0, 1'b0, 1'b0));
    drain();
    wr(2'd3, 32'd0);

    // R10: mid-frame rewrite only applies from the next frame
    cur_tag = "R10 deferred timing";
    ta = 39 * 8;
    tb = 23 * 6;
    push_frame(32, 2, 3, 2, 4, 1, 2, 1, 1'b0, 1'b0);
    push_frame(16, 1, 2, 4, 3, 0, 1, 2, 1'b0, 1'b0);
    wr(2'd3, ctl(1'b1, 2, 1'b0, 1'b0, 1'b0));
    while (exp_q.size() > ta + tb - 100) @(posedge clk);
    set_timing(16, 1, 2, 4, 3, 0, 1, 2);
    drain();
    wr(2'd3, 32'd0);

    // R6 R8: extension bits, wide porches, inverted syncs, odd divisor
    cur_tag = "R6 R8 wide line inverted";
    set_timing(1040, 257, 65, 257, 2, 0, 1, 0);
    push_frame(1040, 257, 65, 257, 2, 0, 1, 0, 1'b1, 1'b1);
    wr(2'd3, ctl(1'b1, 3, 1'b1, 1'b1, 1'b0));
    drain();
    wr(2'd3, 32'd0);

    // R4 R6: line count bit 10
    cur_tag = "R4 R6 1025 lines";
    set_timing(16, 1, 1, 1, 1025, 3, 2, 2);
    push_frame(16, 1, 1, 1, 1025, 3, 2, 2, 1'b0, 1'b0);
    wr(2'd3, ctl(1'b1, 2, 1'b0, 1'b0, 1'b0));
    drain();
    wr(2'd3, 32'd0);

    @(negedge clk);
    chk("R9 final de",    {31'd0, de_o},     32'd0);
    chk("R9 final ce",    {31'd0, pix_ce_o}, 32'd0);
    chk("R9 final hsync", {31'd0, hsync_o},  32'd0);

    summary();
    $finish;
  end
endmodule